// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is the receive half of one port of a 2-D mesh router. Flits arrive from the neighbouring link together with a 3-bit channel tag. The tag steers each 34-bit flit into one of `NUM_VC` per-channel FIFOs. The port has a fixed budget of 16 flit slots, so each FIFO holds `16/NUM_VC` flits. `NUM_VC` may be 1, 2, 4 or 8.

Each channel has its own dimension-ordered (XY) routing unit. This unit looks at the flit at the head of its FIFO and produces a one-hot request for one of the five router outputs. Once a multi-flit packet's header has been read out, the channel keeps that output until the tail has left (wormhole switching).

The crossbar reads a channel with a per-channel pop strobe. Each accepted read sends a credit pulse back to the upstream sender. A flit that arrives for a full FIFO is dropped, and a sticky overflow flag is raised. This can only happen if the sender breaks the credit protocol.

Top module: `vc_in_port`

## Requirements
- R1: After reset, `req_valid_o`, `credit_o` and `overflow_o` are all low.
- R2: A flit with `link_valid_i` high is written only into the FIFO selected by `link_vc_i`. A tag value of `NUM_VC` or more has no effect on any channel.
- R3: Each FIFO holds exactly `16/NUM_VC` flits. A flit offered to a full FIFO that is not being read in the same cycle is dropped, and `overflow_o` goes high and stays high until reset.
- R4: Each channel presents its flits on `head_flit_o` in arrival order. `req_valid_o` is high exactly while its FIFO is non-empty.
- R5: Flit bit 33 marks begin-of-packet and bit 32 marks end-of-packet. The destination X is in bits [3:0] and Y is in bits [7:4]. The request is one-hot: bit 0 Local, bit 1 North, bit 2 East, bit 3 South, bit 4 West. The rules, compared against the router's own `X_POS`/`Y_POS`, are:
  - a larger X goes East, and a smaller X goes West;
  - with X equal, a larger Y goes North, and a smaller Y goes South;
  - when both match, the request is Local.
- R6: After a header without end-of-packet is read, every later flit of that channel requests the header's port, whatever its low bits hold. This lasts up to and including the end-of-packet flit. The next header is routed afresh.
- R7: `credit_o[v]` is high for one cycle right after each edge at which `pop_i[v]` read a flit from a non-empty FIFO. A pop of an empty FIFO returns no credit.
- R8: A write and a read of the same FIFO in one cycle are both performed. This holds even when the FIFO is full, and raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_valid_i | input | 1 | Flit present on link |
| link_flit_i | input | 34 | Flit data |
| link_vc_i | input | 3 | Virtual-channel tag of the flit |
| pop_i | input | NUM_VC | Per-channel read strobe from crossbar |
| credit_o | output | NUM_VC | Per-channel credit pulse to upstream |
| req_valid_o | output | NUM_VC | Channel has a flit to forward |
| req_port_o | output | 5*NUM_VC | One-hot output port request per channel |
| head_flit_o | output | 34*NUM_VC | Head flit of each channel |
| overflow_o | output | 1 | Sticky overflow error |

## Verification
The hardest states to reach are a full FIFO that is written and read in the same cycle, and a wormhole body whose low bits would route elsewhere. The bench fills one channel to its depth and then pushes and pops that channel together. It then drains the channel, checking both the data order and that the flag stayed low. For wormhole hold, the body and tail flits carry coordinates that point West while the header points East. The bench checks the request after every read of that packet.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int FLIT_W  = 34;
  localparam int BOP_BIT = 33;
  localparam int EOP_BIT = 32;
  localparam int COORD_W = 4;
  localparam int NPORT   = 5;
  localparam int TOTAL_SLOTS = 16;

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_EAST  = 3'd2,
    P_SOUTH = 3'd3,
    P_WEST  = 3'd4
  } port_e;
endpackage

// File: rtl/vc_fifo.sv
module vc_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i) wptr_q <= nxt(wptr_q);
      if (rd_i) rptr_q <= nxt(rptr_q);
      if (wr_i && !rd_i)      cnt_q <= cnt_q + 1'b1;
      else if (rd_i && !wr_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/xy_route.sv
module xy_route
  import vcr_pkg::*;
#(
  parameter int X_POS = 0,
  parameter int Y_POS = 0
) (
  input  logic [FLIT_W-1:0] flit_i,
  output logic [NPORT-1:0]  port_oh_o
);
  logic [COORD_W-1:0] dx, dy;
  port_e sel;

  assign dx = flit_i[COORD_W-1:0];
  assign dy = flit_i[2*COORD_W-1:COORD_W];

  always_comb begin
    if (dx > COORD_W'(X_POS))      sel = P_EAST;
    else if (dx < COORD_W'(X_POS)) sel = P_WEST;
    else if (dy > COORD_W'(Y_POS)) sel = P_NORTH;
    else if (dy < COORD_W'(Y_POS)) sel = P_SOUTH;
    else                           sel = P_LOCAL;
  end

  assign port_oh_o = NPORT'(1) << sel;
endmodule

// File: rtl/vc_lane.sv
module vc_lane
  import vcr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int X_POS = 0,
  parameter int Y_POS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FLIT_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic              drop_o,
  output logic              credit_o,
  output logic              req_valid_o,
  output logic [NPORT-1:0]  req_port_o,
  output logic [FLIT_W-1:0] head_o
);
  logic empty, full, rd, wr_ok;
  logic [NPORT-1:0] route;
  logic held_q, credit_q;
  logic [NPORT-1:0] held_port_q;

  assign rd     = pop_i && !empty;
  assign wr_ok  = wr_i && (!full || rd);
  assign drop_o = wr_i && full && !rd;

  vc_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i(wr_ok), .wdata_i,
    .rd_i(rd), .rdata_o(head_o),
    .empty_o(empty), .full_o(full)
  );

  xy_route #(.X_POS(X_POS), .Y_POS(Y_POS)) u_route (
    .flit_i(head_o), .port_oh_o(route)
  );

  // wormhole: header (without tail) locks the port until the tail is read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q      <= 1'b0;
      held_port_q <= '0;
      credit_q    <= 1'b0;
    end else begin
      credit_q <= rd;
      if (rd) begin
        if (head_o[EOP_BIT]) begin
          held_q <= 1'b0;
        end else if (head_o[BOP_BIT] && !held_q) begin
          held_q      <= 1'b1;
          held_port_q <= route;
        end
      end
    end
  end

  assign credit_o    = credit_q;
  assign req_valid_o = !empty;
  assign req_port_o  = held_q ? held_port_q : route;
endmodule

// File: rtl/vc_in_port.sv
module vc_in_port
  import vcr_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int X_POS  = 2,
  parameter int Y_POS  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     link_valid_i,
  input  logic [FLIT_W-1:0]        link_flit_i,
  input  logic [2:0]               link_vc_i,
  input  logic [NUM_VC-1:0]        pop_i,
  output logic [NUM_VC-1:0]        credit_o,
  output logic [NUM_VC-1:0]        req_valid_o,
  output logic [NUM_VC*NPORT-1:0]  req_port_o,
  output logic [NUM_VC*FLIT_W-1:0] head_flit_o,
  output logic                     overflow_o
);
  localparam int DEPTH = TOTAL_SLOTS / NUM_VC;

  logic [NUM_VC-1:0] drop;
  logic ovf_q;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
    logic wr;
    assign wr = link_valid_i && (int'(link_vc_i) == v);

    vc_lane #(.DEPTH(DEPTH), .X_POS(X_POS), .Y_POS(Y_POS)) u_lane (
      .clk_i, .rst_ni,
      .wr_i(wr), .wdata_i(link_flit_i),
      .pop_i(pop_i[v]),
      .drop_o(drop[v]),
      .credit_o(credit_o[v]),
      .req_valid_o(req_valid_o[v]),
      .req_port_o(req_port_o[v*NPORT +: NPORT]),
      .head_o(head_flit_o[v*FLIT_W +: FLIT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_q | (|drop);
  end

  assign overflow_o = ovf_q;
endmodule

// File: rtl/vc_in_port_chk.sv
module vc_in_port_chk
  import vcr_pkg::*;
#(
  parameter int NUM_VC = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_VC-1:0]        pop_i,
  input logic [NUM_VC-1:0]        credit_o,
  input logic [NUM_VC-1:0]        req_valid_o,
  input logic [NUM_VC*NPORT-1:0]  req_port_o,
  input logic [NUM_VC*FLIT_W-1:0] head_flit_o,
  input logic                     overflow_o
);
  // R3
  sticky_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    // R5
    onehot_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o[v] |-> ($countones(req_port_o[v*NPORT +: NPORT]) == 1));
    // R4
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_o[v] && !pop_i[v]) |=>
        (req_valid_o[v] && $stable(req_port_o[v*NPORT +: NPORT])));
    // R6
    worm_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_o[v] && pop_i[v] && !head_flit_o[v*FLIT_W + EOP_BIT]) |=>
        (!req_valid_o[v] || $stable(req_port_o[v*NPORT +: NPORT])));
    // R7
    credit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i[v] && req_valid_o[v]) |=> credit_o[v]);
    // R7
    no_spurious_credit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pop_i[v] && req_valid_o[v]) |=> !credit_o[v]);
  end
endmodule

bind vc_in_port vc_in_port_chk #(.NUM_VC(NUM_VC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pop_i(pop_i), .credit_o(credit_o),
  .req_valid_o(req_valid_o), .req_port_o(req_port_o),
  .head_flit_o(head_flit_o), .overflow_o(overflow_o)
);

// File: tb/sim_vc_in_port.sv
`timescale 1ns/1ps
module sim_vc_in_port;
  localparam int N = 4;
  localparam logic [4:0] LOC = 5'b00001, NOR = 5'b00010, EAS = 5'b00100,
                         SOU = 5'b01000, WES = 5'b10000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic link_valid_i = 1'b0;
  logic [33:0] link_flit_i = '0;
  logic [2:0] link_vc_i = '0;
  logic [N-1:0] pop_i = '0;
  logic [N-1:0] credit_o, req_valid_o;
  logic [N*5-1:0] req_port_o;
  logic [N*34-1:0] head_flit_o;
  logic overflow_o;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  vc_in_port #(.NUM_VC(N), .X_POS(2), .Y_POS(2)) u0 (.*);

  function automatic logic [33:0] hdr(input int x, input int y, input bit b, input bit e);
    return {b, e, 24'h0, 4'(y), 4'(x)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int tag, input logic [33:0] d, input logic [N-1:0] p);
    @(negedge clk_i);
    link_valid_i = v; link_vc_i = 3'(tag); link_flit_i = d; pop_i = p;
    @(posedge clk_i); #1;
  endtask

  task automatic idle(); drive(0, 0, '0, '0); endtask
  function automatic logic [4:0] port(input int v); return req_port_o[v*5 +: 5]; endfunction
  function automatic logic [33:0] head(input int v); return head_flit_o[v*34 +: 34]; endfunction

  task automatic t_reset();
    chk("R1 req_valid", req_valid_o, 0);
    chk("R1 credit", credit_o, 0);
    chk("R1 overflow", overflow_o, 0);
  endtask

  task automatic t_route();
    drive(1, 0, hdr(3, 2, 1, 1), '0);
    drive(1, 1, hdr(1, 5, 1, 1), '0);
    drive(1, 2, hdr(2, 4, 1, 1), '0);
    drive(1, 3, hdr(2, 0, 1, 1), '0);
    drive(1, 5, hdr(0, 0, 1, 1), '0);  // tag out of range
    idle();
    chk("R2 all lanes valid", req_valid_o, 4'b1111);
    chk("R2 tag5 ignored, head0", head(0), hdr(3, 2, 1, 1));
    chk("R5 east", port(0), EAS);
    chk("R5 west", port(1), WES);
    chk("R5 north", port(2), NOR);
    chk("R5 south", port(3), SOU);
    drive(0, 0, '0, 4'b1111);
    chk("R7 credits", credit_o, 4'b1111);
    chk("R2 no extra flit", req_valid_o, 4'b0000);
    idle();
    chk("R7 credit one cycle", credit_o, 0);
  endtask

  task automatic t_worm();
    drive(1, 0, hdr(3, 2, 1, 0), '0);
    drive(1, 0, {2'b00, 32'h0}, '0);   // body low bits point west
    drive(1, 0, {2'b01, 32'h0}, '0);   // tail
    idle();
    chk("R5 header east", port(0), EAS);
    drive(0, 0, '0, 4'b0001);
    chk("R6 body keeps east", port(0), EAS);
    chk("R4 body at head", head(0), {2'b00, 32'h0});
    drive(0, 0, '0, 4'b0001);
    chk("R6 tail keeps east", port(0), EAS);
    drive(0, 0, '0, 4'b0001);
    chk("R4 lane empty", req_valid_o[0], 0);
    drive(1, 0, hdr(2, 2, 1, 1), '0);
    idle();
    chk("R6 reroute local", port(0), LOC);
    drive(0, 0, '0, 4'b0001);
    idle();
  endtask

  task automatic t_simul();
    for (int i = 1; i <= 4; i++) drive(1, 2, {2'b11, 32'(i)}, '0);
    drive(1, 2, {2'b11, 32'd5}, 4'b0100);
    chk("R8 credit", credit_o[2], 1);
    chk("R8 no overflow", overflow_o, 0);
    chk("R8 head", head(2), {2'b11, 32'd2});
    for (int i = 3; i <= 5; i++) begin
      drive(0, 0, '0, 4'b0100);
      chk("R8 order", head(2), {2'b11, 32'(i)});
    end
    drive(0, 0, '0, 4'b0100);
    chk("R8 empty", req_valid_o[2], 0);
    idle();
  endtask

  task automatic t_fill();
    for (int i = 1; i <= 4; i++) drive(1, 1, {2'b11, 32'(16 + i)}, '0);
    idle();
    chk("R3 no ovf at depth", overflow_o, 0);
    drive(1, 1, {2'b11, 32'd99}, '0);
    idle();
    chk("R3 overflow set", overflow_o, 1);
    for (int i = 1; i <= 4; i++) begin
      chk("R4 fifo order", head(1), {2'b11, 32'(16 + i)});
      drive(0, 0, '0, 4'b0010);
    end
    chk("R3 dropped flit absent", req_valid_o[1], 0);
    drive(0, 0, '0, 4'b0010);
    chk("R7 no credit on empty", credit_o[1], 0);
    idle();
    chk("R3 sticky", overflow_o, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #12 t_reset();
    #20 rst_ni = 1'b1;
    idle();
    t_route();
    t_worm();
    t_simul();
    t_fill();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule